// File: doc/BRIEF.md
# Protection region bounds decoder

This block turns the mode field and address register of every memory-protection entry into an inclusive pair of byte addresses: a start and an end. An access checker compares these bounds with a request address. Each address register holds bits [XLEN+1:2] of a physical address, so a physical address is two bits wider than the register.

Four modes are supported. In the disabled mode the entry covers the whole space. In top-of-range mode the entry runs from the register of the entry below it up to its own register. The four-byte mode covers one aligned word. In the power-of-two mode the size is encoded by the run of trailing ones in the register. Every entry is decoded by its own slice. The bounds are registered, so each entry's result appears one clock after its inputs settle. The block has no register-access port of its own.

The block has no sequencing control. Each entry slice has a single operating condition: it reloads its bound registers on every clock edge once reset is released. Held in reset, the bounds show the disabled-mode span.

Top module: `pmp_span_decoder`

## Requirements
- R1: While reset is asserted, and right after it, every entry reports start 0 and end all ones (PA_W = XLEN+2 bits).
- R2: The bounds of an entry change at the first rising clock edge after its inputs change, and not before. They hold while the inputs hold.
- R3: Entry i takes its mode from mode_i[2i+1:2i], where 0 is disabled, 1 is top-of-range, 2 is four-byte and 3 is power-of-two. In the disabled mode the start is 0 and the end is all ones.
- R4: In top-of-range mode the start is the register of entry i-1 followed by two zero bits. Entry 0 uses zero as its lower register.
- R5: In top-of-range mode the end is the entry's own register followed by two zero bits, minus one, modulo 2^PA_W. A zero register therefore gives an end of all ones.
- R6: In four-byte mode the start is the register followed by two zero bits, and the end is the start plus 3.
- R7: In power-of-two mode, let t be the number of trailing one bits of the register. The start is the register with its low t bits cleared, followed by two zero bits. The end is the start plus 2^(t+3) - 1.
- R8: In power-of-two mode a register of all ones gives a start of 0 and an end of all ones.
- R9: In power-of-two mode a register whose top bit is zero and whose other bits are all ones also spans 0 to all ones.
- R10: Entry i's register is addr_i[i*XLEN +: XLEN]. Its bounds are start_o[i*PA_W +: PA_W] and end_o[i*PA_W +: PA_W]. A change to one entry's register alters only its own bounds and the start of the entry above it when that entry is in top-of-range mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2*NUM_ENTRIES | Packed per-entry mode fields |
| addr_i | input | XLEN*NUM_ENTRIES | Packed per-entry address registers |
| start_o | output | PA_W*NUM_ENTRIES | Packed inclusive start byte addresses |
| end_o | output | PA_W*NUM_ENTRIES | Packed inclusive end byte addresses |

## Verification
The assertions check every cycle that these rules hold for every entry:
- a disabled entry spans the whole space;
- a four-byte entry spans exactly four bytes;
- a power-of-two entry is aligned to its own size;
- an all-ones power-of-two register spans everything;
- a top-of-range start tracks the lower entry's register.

Only the bench scenarios can show the exact end values:
- the trailing-ones size for specific t;
- the modular wrap of a zero top-of-range register;
- the one-cycle latency;
- the slice packing and the independence between entries.

// File: rtl/pmp_span_pkg.sv
package pmp_span_pkg;

    typedef enum logic [1:0] {
        SPAN_OFF   = 2'd0,
        SPAN_TOR   = 2'd1,
        SPAN_NA4   = 2'd2,
        SPAN_NAPOT = 2'd3
    } span_mode_e;

endpackage

// File: rtl/tz_ones_count.sv
module tz_ones_count #(
    parameter int W     = 32,
    parameter int CNT_W = $clog2(W + 1)
) (
    input  logic [W-1:0]     value_i,
    output logic [CNT_W-1:0] count_o,
    output logic             all_ones_o
);

    // Priority encoder over the inverted value: the lowest zero bit wins.
    always_comb begin
        count_o = CNT_W'(W);
        for (int i = W - 1; i >= 0; i--) begin
            if (!value_i[i]) begin
                count_o = CNT_W'(i);
            end
        end
    end

    assign all_ones_o = &value_i;

endmodule

// File: rtl/pmp_span_entry.sv
module pmp_span_entry
    import pmp_span_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int PA_W = XLEN + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  span_mode_e      mode_i,
    input  logic [XLEN-1:0] cur_addr_i,
    input  logic [XLEN-1:0] prev_addr_i,
    output logic [PA_W-1:0] lo_o,
    output logic [PA_W-1:0] hi_o
);

    localparam int CNT_W = $clog2(XLEN + 1);
    localparam int SHW   = CNT_W + 2;

    logic [CNT_W-1:0] ones_cnt;
    logic             ones_all;
    logic [SHW-1:0]   napot_shift;
    logic [PA_W-1:0]  cur_pa;
    logic [PA_W-1:0]  prev_pa;
    logic [PA_W-1:0]  napot_mask;
    logic [PA_W-1:0]  lo_d;
    logic [PA_W-1:0]  hi_d;

    tz_ones_count #(
        .W     (XLEN),
        .CNT_W (CNT_W)
    ) i_tz_ones_count (
        .value_i    (cur_addr_i),
        .count_o    (ones_cnt),
        .all_ones_o (ones_all)
    );

    assign cur_pa      = {cur_addr_i, 2'b00};
    assign prev_pa     = {prev_addr_i, 2'b00};
    assign napot_shift = SHW'(ones_cnt) + SHW'(3);
    assign napot_mask  = ~({PA_W{1'b1}} << napot_shift);

    // Next-bound decode, one arm per mode.
    always_comb begin
        lo_d = '0;
        hi_d = '1;
        unique case (mode_i)
            SPAN_OFF: begin
                lo_d = '0;
                hi_d = '1;
            end
            SPAN_TOR: begin
                lo_d = prev_pa;
                hi_d = cur_pa - PA_W'(1);
            end
            SPAN_NA4: begin
                lo_d = cur_pa;
                hi_d = cur_pa + PA_W'(3);
            end
            SPAN_NAPOT: begin
                if (ones_all) begin
                    lo_d = '0;
                    hi_d = '1;
                end else begin
                    lo_d = cur_pa & ~napot_mask;
                    hi_d = (cur_pa & ~napot_mask) | napot_mask;
                end
            end
            default: begin
                lo_d = '0;
                hi_d = '1;
            end
        endcase
    end

    // Bound registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_o <= '0;
            hi_o <= '1;
        end else begin
            lo_o <= lo_d;
            hi_o <= hi_d;
        end
    end

    logic [PA_W-1:0] span_w;
    assign span_w = hi_o - lo_o;

    // R3
    off_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == SPAN_OFF) |=> (lo_o == '0) && (&hi_o));

    // R6
    na4_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == SPAN_NA4) |=> (span_w == PA_W'(3)));

    // R7
    napot_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == SPAN_NAPOT) |=>
            (((span_w & (span_w + PA_W'(1))) == '0) && ((lo_o & span_w) == '0)));

    // R8
    napot_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_i == SPAN_NAPOT) && (&cur_addr_i)) |=> (lo_o == '0) && (&hi_o));

    // R4
    tor_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == SPAN_TOR) |=> (lo_o == {$past(prev_addr_i), 2'b00}));

endmodule

// File: rtl/pmp_span_decoder.sv
module pmp_span_decoder
    import pmp_span_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    parameter int XLEN        = 32,
    parameter int PA_W        = XLEN + 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [2*NUM_ENTRIES-1:0]    mode_i,
    input  logic [XLEN*NUM_ENTRIES-1:0] addr_i,
    output logic [PA_W*NUM_ENTRIES-1:0] start_o,
    output logic [PA_W*NUM_ENTRIES-1:0] end_o
);

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
        logic [XLEN-1:0] lower_addr;

        if (g == 0) begin : g_base
            assign lower_addr = '0;
        end else begin : g_chain
            assign lower_addr = addr_i[(g-1)*XLEN +: XLEN];
        end

        pmp_span_entry #(
            .XLEN (XLEN),
            .PA_W (PA_W)
        ) i_pmp_span_entry (
            .clk         (clk),
            .rst_n       (rst_n),
            .mode_i      (span_mode_e'(mode_i[2*g +: 2])),
            .cur_addr_i  (addr_i[g*XLEN +: XLEN]),
            .prev_addr_i (lower_addr),
            .lo_o        (start_o[g*PA_W +: PA_W]),
            .hi_o        (end_o[g*PA_W +: PA_W])
        );
    end

endmodule

// File: tb/test_pmp_span_decoder.sv
module test_pmp_span_decoder;

    localparam int N  = 4;
    localparam int XW = 32;
    localparam int PW = XW + 2;

    logic              clk;
    logic              rst_n;
    logic [2*N-1:0]    mode_i;
    logic [XW*N-1:0]   addr_i;
    logic [PW*N-1:0]   start_o;
    logic [PW*N-1:0]   end_o;

    logic [1:0]    m [N];
    logic [XW-1:0] a [N];

    int total = 0;
    int bad   = 0;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            mode_i[2*i +: 2]  = m[i];
            addr_i[XW*i +: XW] = a[i];
        end
    end

    pmp_span_decoder #(
        .NUM_ENTRIES (N),
        .XLEN        (XW),
        .PA_W        (PW)
    ) i_pmp_span_decoder (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode_i),
        .addr_i  (addr_i),
        .start_o (start_o),
        .end_o   (end_o)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    // Independent model of the expected bounds.
    function automatic void model(input int i, output logic [PW-1:0] lo, output logic [PW-1:0] hi);
        logic [XW-1:0] below;
        logic [35:0]   base;
        logic [35:0]   top;
        int            t;
        below = (i == 0) ? '0 : a[(i == 0) ? 0 : i - 1];
        case (m[i])
            2'd0: begin lo = '0; hi = '1; end
            2'd1: begin lo = {below, 2'b00}; hi = {a[i], 2'b00} - 1; end
            2'd2: begin lo = {a[i], 2'b00}; hi = {a[i], 2'b00} + 3; end
            default: begin
                t = 0;
                while (t < XW && a[i][t]) t++;
                base = (t >= XW) ? 36'd0 : ((36'(a[i]) >> t) << t);
                base = base * 4;
                top  = base + (36'd1 << (t + 3)) - 36'd1;
                lo = base[PW-1:0];
                hi = top[PW-1:0];
            end
        endcase
    endfunction

    task automatic check(input string tag, input logic [PW-1:0] got, input logic [PW-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic check_all(input string tag);
        logic [PW-1:0] lo, hi;
        for (int i = 0; i < N; i++) begin
            model(i, lo, hi);
            check($sformatf("%s entry%0d start", tag, i), start_o[PW*i +: PW], lo);
            check($sformatf("%s entry%0d end", tag, i), end_o[PW*i +: PW], hi);
        end
    endtask

    task automatic settle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic test_reset();
        for (int i = 0; i < N; i++) begin m[i] = 2'd2; a[i] = 32'h1234_0000 + i; end
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < N; i++) begin
            check($sformatf("R1 reset entry%0d start", i), start_o[PW*i +: PW], '0);
            check($sformatf("R1 reset entry%0d end", i), end_o[PW*i +: PW], '1);
        end
        rst_n = 1'b1;
        settle();
        check_all("R6 R10 four-byte after reset");
    endtask

    task automatic test_off();
        for (int i = 0; i < N; i++) begin m[i] = 2'd0; a[i] = 32'hDEAD_0000 ^ i; end
        settle();
        check_all("R3 disabled");
    endtask

    task automatic test_tor();
        m[0] = 2'd1; a[0] = 32'h0000_0100;
        m[1] = 2'd1; a[1] = 32'h0000_0400;
        m[2] = 2'd1; a[2] = 32'h0000_0000;
        m[3] = 2'd1; a[3] = 32'hFFFF_FFFF;
        settle();
        check_all("R4 R5 top-of-range");
        check("R5 zero register wraps", end_o[PW*2 +: PW], '1);
        check("R4 entry0 base zero", start_o[PW*0 +: PW], '0);
    endtask

    task automatic test_na4();
        m[0] = 2'd2; a[0] = 32'h0000_0000;
        m[1] = 2'd2; a[1] = 32'h8000_0001;
        m[2] = 2'd2; a[2] = 32'h0ABC_DEF0;
        m[3] = 2'd2; a[3] = 32'hFFFF_FFFF;
        settle();
        check_all("R6 four-byte");
    endtask

    task automatic test_napot();
        m[0] = 2'd3; a[0] = 32'h0000_1000;
        m[1] = 2'd3; a[1] = 32'h2000_0007;
        m[2] = 2'd3; a[2] = 32'h0000_00FF;
        m[3] = 2'd3; a[3] = 32'h1234_5670;
        settle();
        check_all("R7 power-of-two");
        check("R7 t=3 start", start_o[PW*1 +: PW], 34'h0_8000_0000);
        check("R7 t=3 end", end_o[PW*1 +: PW], 34'h0_8000_003F);
    endtask

    task automatic test_napot_full();
        m[0] = 2'd3; a[0] = 32'hFFFF_FFFF;
        m[1] = 2'd3; a[1] = 32'h7FFF_FFFF;
        m[2] = 2'd3; a[2] = 32'hBFFF_FFFF;
        m[3] = 2'd0; a[3] = 32'h0;
        settle();
        check_all("R8 R9 wide power-of-two");
        check("R8 all ones end", end_o[PW*0 +: PW], '1);
        check("R9 top bit clear start", start_o[PW*1 +: PW], '0);
        check("R9 top bit clear end", end_o[PW*1 +: PW], '1);
    endtask

    task automatic test_latency_and_chain();
        m[0] = 2'd2; a[0] = 32'h0000_0010;
        m[1] = 2'd2; a[1] = 32'h0000_0020;
        m[2] = 2'd1; a[2] = 32'h0000_0040;
        m[3] = 2'd2; a[3] = 32'h0000_0080;
        settle();
        check_all("R10 chain baseline");
        a[1] = 32'h0000_0030;
        #5;
        check("R2 no early change", start_o[PW*2 +: PW], 34'h80);
        settle();
        check_all("R2 R10 after lower register change");
        check("R10 entry3 untouched", start_o[PW*3 +: PW], 34'h200);
        settle();
        check_all("R2 hold");
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin m[i] = 2'd0; a[i] = '0; end
        rst_n = 1'b0;
        @(negedge clk);
        test_reset();
        test_off();
        test_tor();
        test_na4();
        test_napot();
        test_napot_full();
        test_latency_and_chain();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule